// File: doc/BRIEF.md
# 10BASE-T Jabber and SQE Monitor

This block watches the transmit-enable line of a 10 Mb/s Ethernet transmitter. Each time a frame ends, it sends a short signal-quality-error (SQE) test pulse on the collision output. This lets the attached MAC confirm that the collision path works.

The block also guards against a transmitter that stays on too long. If transmit-enable stays asserted past an on-time limit, the block enters jabber lockout. During lockout it removes the transmitter gate and holds collision high. The lockout lasts until transmit-enable has been idle for a much longer quiet time.

All three timings are parameters counted in clock cycles. The defaults correspond to a 25 MHz clock: a 1 µs pulse, a 20 ms on-time limit and a 250 ms quiet time. A bench can therefore use much smaller values. A mode input turns the whole function off when the port is not running 10BASE-T.

Top module: `jabber_sqe_guard`

## Requirements
- R1: After reset, `col` is 0 and `tx_gate` is 1.
- R2: In 10BASE-T mode, when `tx_en` is sampled low on the clock edge after a high sample and no lockout is active, `col` goes high after that edge. It stays high for exactly `SQE_CYC` cycles.
- R3: A frame of at most `JAB_CYC` consecutive high samples of `tx_en` never trips the lockout: `tx_gate` stays 1 throughout.
- R4: On the edge that samples `tx_en` high for the (`JAB_CYC`+1)-th consecutive time, the block enters lockout. After that edge `tx_gate` is 0 and `col` is 1.
- R5: Lockout holds `col` at 1 and `tx_gate` at 0. It ends on the edge that samples `tx_en` low for the (`QUIET_CYC`+1)-th consecutive time. After that edge `col` is 0 and `tx_gate` is 1.
- R6: During lockout, a high sample of `tx_en` restarts the quiet count from zero. The lockout then needs a fresh run of `QUIET_CYC`+1 low samples to end.
- R7: When `tx_en` falls while lockout is active, no SQE pulse is issued, either then or when the lockout ends.
- R8: While `mode_10bt` is 0, `col` is 0 and `tx_gate` is 1. Any lockout and pending pulse are cleared, so the block resumes idle when the mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit-enable from the MAC |
| mode_10bt | input | 1 | 1 when the port runs 10BASE-T; enables the function |
| col | output | 1 | Collision indication: SQE pulse or lockout |
| tx_gate | output | 1 | 1 allows the transmitter to drive the line |

## Verification
Assertions check several properties on every cycle:
- a frame end outside lockout is followed by collision;
- lockout always shows as collision with the gate removed;
- lockout starts only on a high sample and ends only on a low sample;
- leaving 10BASE-T mode clears the lockout.

The exact length of the SQE pulse is shown only by the bench's scenarios. So are the precise trip and release cycles, the quiet-timer restart and the absence of a pulse after a locked-out frame. The bench sweeps frame lengths across the trip threshold to cover these.

// File: rtl/jabber_sqe_guard.sv
module jabber_sqe_guard #(
  parameter int SQE_CYC   = 25,
  parameter int JAB_CYC   = 500_000,
  parameter int QUIET_CYC = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic mode_10bt,
  output logic col,
  output logic tx_gate
);
  localparam int SW = $clog2(SQE_CYC + 1);
  localparam int JW = $clog2(JAB_CYC + 1);
  localparam int QW = $clog2(QUIET_CYC + 1);

  logic          tx_en_q;
  logic          jab;
  logic [SW-1:0] sqe_cnt;
  logic [JW-1:0] on_cnt;
  logic [QW-1:0] quiet_cnt;

  wire frame_end = tx_en_q & ~tx_en;
  wire sqe_busy  = (sqe_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_en_q <= 1'b0;
    else        tx_en_q <= tx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jab       <= 1'b0;
      on_cnt    <= '0;
      quiet_cnt <= '0;
    end else if (!mode_10bt) begin
      jab       <= 1'b0;
      on_cnt    <= '0;
      quiet_cnt <= '0;
    end else if (!jab) begin
      quiet_cnt <= '0;
      if (!tx_en) on_cnt <= '0;
      else if (on_cnt == JW'(JAB_CYC)) begin
        jab    <= 1'b1;
        on_cnt <= '0;
      end else on_cnt <= on_cnt + JW'(1);
    end else begin
      on_cnt <= '0;
      if (tx_en) quiet_cnt <= '0;
      else if (quiet_cnt == QW'(QUIET_CYC)) begin
        jab       <= 1'b0;
        quiet_cnt <= '0;
      end else quiet_cnt <= quiet_cnt + QW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sqe_cnt <= '0;
    else if (!mode_10bt)              sqe_cnt <= '0;
    else if (frame_end && !jab)       sqe_cnt <= SW'(SQE_CYC);
    else if (sqe_busy)                sqe_cnt <= sqe_cnt - SW'(1);
  end

  assign col     = mode_10bt & (jab | sqe_busy);
  assign tx_gate = ~(mode_10bt & jab);

  p_sqe_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_10bt && !jab && frame_end) |=> (col || !mode_10bt));

  p_trip_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab) |-> ($past(tx_en) && $past(mode_10bt)));

  p_lock_shows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (jab && mode_10bt) |-> (col && !tx_gate));

  p_release_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(jab) && $past(mode_10bt)) |-> !$past(tx_en));

  p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_10bt |=> (!jab && !sqe_busy));

  p_pulse_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_cnt <= SW'(SQE_CYC));
endmodule

// File: tb/jabber_sqe_guard_tb.sv
module jabber_sqe_guard_tb;
  localparam int S = 3;
  localparam int J = 10;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic mode_10bt = 1'b1;
  logic col, tx_gate;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  jabber_sqe_guard #(.SQE_CYC(S), .JAB_CYC(J), .QUIET_CYC(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_10bt(mode_10bt),
    .col(col), .tx_gate(tx_gate));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic t);
    tx_en = t;
    @(negedge clk);
  endtask

  task automatic low_window(input int exp_col, input int exp_gl, input string req);
    int c = 0;
    int g = 0;
    for (int k = 0; k < Q + S + 4; k++) begin
      tick(1'b0);
      if (col) c++;
      if (!tx_gate) g++;
    end
    chk(c == exp_col, req, c, exp_col);
    chk(g == exp_gl, req, g, exp_gl);
  endtask

  task automatic frame(input int len, input bit on);
    int bad = 0;
    int exp_c, exp_g;
    bit jb;
    for (int i = 0; i < len; i++) begin
      tick(1'b1);
      jb = on && (i >= J);
      if (col != jb || tx_gate != !jb) bad++;
    end
    chk(bad == 0, (len > J && on) ? "R4" : "R3", bad, 0);
    tick(1'b0);
    exp_c = !on ? 0 : 1;
    chk(col == exp_c, (len > J) ? "R5" : "R2", col, exp_c);
    exp_c = !on ? 0 : (len > J ? Q - 1 : S - 1);
    exp_g = (on && len > J) ? Q - 1 : 0;
    low_window(exp_c, exp_g, !on ? "R8" : (len > J ? "R7" : "R2"));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(col == 1'b0, "R1", col, 0);
    chk(tx_gate == 1'b1, "R1", tx_gate, 1);
    rst_n = 1'b1;
    tick(1'b0);
    chk(col == 1'b0 && tx_gate == 1'b1, "R1", col, 0);

    for (int L = 1; L <= J + 4; L++) frame(L, 1'b1);

    mode_10bt = 1'b0;
    for (int L = 1; L <= J + 4; L += 6) frame(L, 1'b0);
    mode_10bt = 1'b1;

    for (int i = 0; i < J + 1; i++) tick(1'b1);
    chk(col && !tx_gate, "R4", col, 1);
    for (int i = 0; i < Q / 2; i++) tick(1'b0);
    tick(1'b1);
    chk(col && !tx_gate, "R6", col, 1);
    low_window(Q, Q, "R6");

    for (int i = 0; i < J + 1; i++) tick(1'b1);
    for (int i = 0; i < 3; i++) tick(1'b0);
    mode_10bt = 1'b0;
    tick(1'b0);
    chk(col == 1'b0 && tx_gate == 1'b1, "R8", col, 0);
    mode_10bt = 1'b1;
    low_window(0, 0, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule